// File: doc/BRIEF.md
# Clock Mode Supervisor with Loss Fallback

This block tracks which source mode a clock generator runs in. Software writes a requested mode, a one-time reference-select bit and three enables through a single control write. The block reports the mode it has actually reached, and that mode can lag behind the request or differ from it. A request is held pending until the external oscillator is ready, or until the frequency-locked loop reports lock.

When a reference-clock loss or an oscillator-clock loss is reported, the block drops to a safer mode by itself. It rewrites both the requested and the reported mode to show where it landed. It also keeps a clock-loss flag and a lock-loss flag. Software clears both flags with a status read followed by a write-one clear. Each flag raises either an interrupt or a one-cycle reset request. The oscillator, the loop, the clock muxes and the loss detectors sit outside the block, which only sees their pulses and levels.

Top module: `clk_mode_sup`

## Requirements
- R1: After reset, both mode fields read 00, both flags are 0, `refsel_o` and `osc_en_o` are 0, and `irq_o` and `rst_req_o` are 0.
- R2: Mode codes are 00 self-clocked (SCM), 01 loop-engaged internal (FEI), 10 loop-bypassed external (FBE) and 11 loop-engaged external (FEE). A control write shows on `req_mode_o` one cycle later. `act_mode_o` follows it one cycle after that, provided the conditions in R3 and R4 are met.
- R3: A request for an external mode (bit 1 set) leaves `act_mode_o` unchanged until `osc_rdy_i` is high while the oscillator is enabled.
- R4: A request for a loop-engaged mode (bit 0 set) leaves `act_mode_o` unchanged until `lock_i` is high.
- R5: A reference loss while in FBE or FEE sets both mode fields to SCM on the next cycle.
- R6: An oscillator-clock loss while in FEE sets both mode fields to FBE on the next cycle. If a reference loss arrives in the same cycle, it wins and the result is SCM.
- R7: Every honoured loss sets the clock-loss flag. A loss taken in FEI or FEE also sets the lock-loss flag.
- R8: A `clr_flag_i` clears both flags only when a `rd_stat_i` has come before it since the last clear. A clear with no read before it is ignored. A new loss in the clearing cycle wins.
- R9: `irq_o` is high when interrupts are enabled and a flag is set whose reset enable is 0. A set lock-loss flag with its reset enable at 1 suppresses the interrupt entirely.
- R10: `rst_req_o` pulses high for exactly one cycle, in the cycle after a loss, when the loss sets a flag whose reset enable is 1.
- R11: `refsel_o` takes its value only from the first control write after reset. Later writes leave it unchanged. `osc_en_o` follows it, so a first write of 0 blocks external modes until reset.
- R12: After reset, or after a reference-loss fallback from FBE, oscillator-clock losses are ignored until `osc_stable_i` has been seen high.
- R13: A fall of `lock_i` while in FEI or FEE sets the lock-loss flag and leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_ctrl_i | input | 1 | Control write strobe |
| wr_mode_i | input | 2 | Requested mode on write |
| wr_refsel_i | input | 1 | Reference select (first write only) |
| wr_ie_i | input | 1 | Interrupt enable |
| wr_loc_rst_en_i | input | 1 | Clock-loss reset enable |
| wr_lol_rst_en_i | input | 1 | Lock-loss reset enable |
| rd_stat_i | input | 1 | Status read strobe, arms the clear |
| clr_flag_i | input | 1 | Write-one flag clear strobe |
| ref_loss_i | input | 1 | Reference clock loss pulse |
| osc_loss_i | input | 1 | Oscillator clock loss pulse |
| osc_stable_i | input | 1 | Oscillator clock stable level |
| osc_rdy_i | input | 1 | External oscillator ready level |
| lock_i | input | 1 | Loop lock level |
| req_mode_o | output | 2 | Requested mode field |
| act_mode_o | output | 2 | Reached mode field |
| refsel_o | output | 1 | Reference select held |
| osc_en_o | output | 1 | External oscillator enable |
| loc_flag_o | output | 1 | Clock-loss flag |
| lol_flag_o | output | 1 | Lock-loss flag |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Responses to loss pulses, clears and level changes on `lock_i` and `osc_rdy_i` are due one cycle after the stimulus. A mode write shows on `req_mode_o` after one cycle and on `act_mode_o` after two. Each stimulus pushes its expected fields into a queue and tags them with the cycle in which they fall due. A monitor samples one nanosecond after each rising edge and compares only the items due in that cycle. Pending cases are checked a few cycles past their due point, so that a wrongly early transition is caught.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  localparam int MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    M_SCM = 2'b00,
    M_FEI = 2'b01,
    M_FBE = 2'b10,
    M_FEE = 2'b11
  } mode_e;

  function automatic logic is_ext(input mode_e m);
    return m[1];
  endfunction

  function automatic logic is_fll(input mode_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_ctrl_i,
  input  mode_e wr_mode_i,
  input  logic  wr_refsel_i,
  input  logic  wr_ie_i,
  input  logic  wr_loc_rst_en_i,
  input  logic  wr_lol_rst_en_i,
  input  logic  fb_vld_i,
  input  mode_e fb_mode_i,
  output mode_e req_mode_o,
  output logic  refsel_o,
  output logic  ie_o,
  output logic  loc_rst_en_o,
  output logic  lol_rst_en_o
);
  logic written_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_mode_o   <= M_SCM;
      refsel_o     <= 1'b0;
      written_q    <= 1'b0;
      ie_o         <= 1'b0;
      loc_rst_en_o <= 1'b0;
      lol_rst_en_o <= 1'b0;
    end else begin
      if (wr_ctrl_i) begin
        ie_o         <= wr_ie_i;
        loc_rst_en_o <= wr_loc_rst_en_i;
        lol_rst_en_o <= wr_lol_rst_en_i;
        written_q    <= 1'b1;
        if (!written_q) refsel_o <= wr_refsel_i;
      end
      // hardware fallback overrides a concurrent software request
      if (fb_vld_i)       req_mode_o <= fb_mode_i;
      else if (wr_ctrl_i) req_mode_o <= wr_mode_i;
    end
  end
endmodule

// File: rtl/clk_mode_track.sv
module clk_mode_track
  import clk_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e req_mode_i,
  input  logic  osc_en_i,
  input  logic  osc_rdy_i,
  input  logic  lock_i,
  input  logic  ref_loss_i,
  input  logic  osc_loss_i,
  input  logic  osc_stable_i,
  output mode_e act_mode_o,
  output logic  fb_vld_o,
  output mode_e fb_mode_o,
  output logic  loss_o,
  output logic  loss_fll_o
);
  logic  osc_mon_q;
  logic  ref_hit, osc_hit, ext_ok, fll_ok;
  mode_e act_d;

  assign ref_hit = ref_loss_i & is_ext(act_mode_o);
  assign osc_hit = osc_loss_i & osc_mon_q & is_fll(act_mode_o);

  always_comb begin
    fb_vld_o  = 1'b0;
    fb_mode_o = act_mode_o;
    if (ref_hit) begin
      fb_vld_o  = 1'b1;
      fb_mode_o = M_SCM;
    end else if (osc_hit && act_mode_o == M_FEE) begin
      fb_vld_o  = 1'b1;
      fb_mode_o = M_FBE;
    end
  end

  assign loss_o     = ref_hit | osc_hit;
  assign loss_fll_o = loss_o & is_fll(act_mode_o);

  assign ext_ok = !is_ext(req_mode_i) || (osc_rdy_i && osc_en_i);
  assign fll_ok = !is_fll(req_mode_i) || lock_i;

  always_comb begin
    act_d = act_mode_o;
    if (fb_vld_o)                                         act_d = fb_mode_o;
    else if (req_mode_i != act_mode_o && ext_ok && fll_ok) act_d = req_mode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_mode_o <= M_SCM;
      osc_mon_q  <= 1'b0;
    end else begin
      act_mode_o <= act_d;
      if (ref_hit && act_mode_o == M_FBE) osc_mon_q <= 1'b0;
      else if (osc_stable_i)              osc_mon_q <= 1'b1;
    end
  end
endmodule

// File: rtl/clk_mode_flags.sv
module clk_mode_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic loss_i,
  input  logic loss_fll_i,
  input  logic act_fll_i,
  input  logic lock_i,
  input  logic rd_stat_i,
  input  logic clr_flag_i,
  input  logic ie_i,
  input  logic loc_rst_en_i,
  input  logic lol_rst_en_i,
  output logic loc_flag_o,
  output logic lol_flag_o,
  output logic irq_o,
  output logic rst_req_o
);
  logic armed_q, lock_q;
  logic loc_set, lol_set, do_clr;

  assign loc_set = loss_i;
  assign lol_set = loss_fll_i | (lock_q & ~lock_i & act_fll_i);
  assign do_clr  = clr_flag_i & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_flag_o <= 1'b0;
      lol_flag_o <= 1'b0;
      armed_q    <= 1'b0;
      lock_q     <= 1'b0;
      rst_req_o  <= 1'b0;
    end else begin
      lock_q <= lock_i;
      if (clr_flag_i)     armed_q <= 1'b0;
      else if (rd_stat_i) armed_q <= 1'b1;
      if (loc_set)     loc_flag_o <= 1'b1;
      else if (do_clr) loc_flag_o <= 1'b0;
      if (lol_set)     lol_flag_o <= 1'b1;
      else if (do_clr) lol_flag_o <= 1'b0;
      rst_req_o <= (loc_set & loc_rst_en_i) | (lol_set & lol_rst_en_i);
    end
  end

  // a lock-loss reset pre-empts any pending interrupt
  assign irq_o = ie_i & ~(lol_flag_o & lol_rst_en_i)
               & ((loc_flag_o & ~loc_rst_en_i) | (lol_flag_o & ~lol_rst_en_i));
endmodule

// File: rtl/clk_mode_sup.sv
module clk_mode_sup
  import clk_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic [MODE_W-1:0] wr_mode_i,
  input  logic              wr_refsel_i,
  input  logic              wr_ie_i,
  input  logic              wr_loc_rst_en_i,
  input  logic              wr_lol_rst_en_i,
  input  logic              rd_stat_i,
  input  logic              clr_flag_i,
  input  logic              ref_loss_i,
  input  logic              osc_loss_i,
  input  logic              osc_stable_i,
  input  logic              osc_rdy_i,
  input  logic              lock_i,
  output logic [MODE_W-1:0] req_mode_o,
  output logic [MODE_W-1:0] act_mode_o,
  output logic              refsel_o,
  output logic              osc_en_o,
  output logic              loc_flag_o,
  output logic              lol_flag_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  mode_e req_m, act_m, fb_m;
  logic  fb_vld, loss, loss_fll, ie, loc_en, lol_en, refsel;

  clk_mode_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_ctrl_i,
    .wr_mode_i       (mode_e'(wr_mode_i)),
    .wr_refsel_i, .wr_ie_i, .wr_loc_rst_en_i, .wr_lol_rst_en_i,
    .fb_vld_i        (fb_vld),
    .fb_mode_i       (fb_m),
    .req_mode_o      (req_m),
    .refsel_o        (refsel),
    .ie_o            (ie),
    .loc_rst_en_o    (loc_en),
    .lol_rst_en_o    (lol_en)
  );

  clk_mode_track u_track (
    .clk_i, .rst_ni,
    .req_mode_i   (req_m),
    .osc_en_i     (refsel),
    .osc_rdy_i, .lock_i, .ref_loss_i, .osc_loss_i, .osc_stable_i,
    .act_mode_o   (act_m),
    .fb_vld_o     (fb_vld),
    .fb_mode_o    (fb_m),
    .loss_o       (loss),
    .loss_fll_o   (loss_fll)
  );

  clk_mode_flags u_flags (
    .clk_i, .rst_ni,
    .loss_i       (loss),
    .loss_fll_i   (loss_fll),
    .act_fll_i    (is_fll(act_m)),
    .lock_i, .rd_stat_i, .clr_flag_i,
    .ie_i         (ie),
    .loc_rst_en_i (loc_en),
    .lol_rst_en_i (lol_en),
    .loc_flag_o, .lol_flag_o, .irq_o, .rst_req_o
  );

  assign req_mode_o = req_m;
  assign act_mode_o = act_m;
  assign refsel_o   = refsel;
  assign osc_en_o   = refsel;
endmodule

// File: rtl/clk_mode_sup_chk.sv
module clk_mode_sup_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_loss_i,
  input logic       osc_loss_i,
  input logic       osc_rdy_i,
  input logic       lock_i,
  input logic       wr_ctrl_i,
  input logic [1:0] req_mode_o,
  input logic [1:0] act_mode_o,
  input logic       refsel_o,
  input logic       loc_flag_o,
  input logic       lol_flag_o,
  input logic       irq_o,
  input logic       rst_req_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  p_ref_fallback_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode_o[1] && ref_loss_i) |=> (act_mode_o == 2'b00 && req_mode_o == 2'b00));

  p_osc_fallback_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode_o == 2'b11 && osc_loss_i && !ref_loss_i) |=> (act_mode_o[1] && req_mode_o == act_mode_o));

  p_ext_needs_rdy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && act_mode_o[1] && !$past(act_mode_o[1])) |-> $past(osc_rdy_i));

  p_fll_needs_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && act_mode_o[0] && !$past(act_mode_o[0])) |-> $past(lock_i));

  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (loc_flag_o || lol_flag_o));

  p_rst_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (loc_flag_o || lol_flag_o));

  p_refsel_no_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> !$fell(refsel_o));

  p_refsel_rise_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(refsel_o)) |-> $past(wr_ctrl_i));
endmodule

bind clk_mode_sup clk_mode_sup_chk u_chk (.*);

// File: tb/clk_mode_sup_tb_top.sv
`timescale 1ns/1ps
module clk_mode_sup_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_ctrl_i = 0, wr_refsel_i = 0, wr_ie_i = 0, wr_loc_rst_en_i = 0, wr_lol_rst_en_i = 0;
  logic [1:0] wr_mode_i = 2'b00;
  logic rd_stat_i = 0, clr_flag_i = 0, ref_loss_i = 0, osc_loss_i = 0;
  logic osc_stable_i = 1, osc_rdy_i = 0, lock_i = 0;
  logic [1:0] req_mode_o, act_mode_o;
  logic refsel_o, osc_en_o, loc_flag_o, lol_flag_o, irq_o, rst_req_o;

  always #2 clk_i = ~clk_i;

  clk_mode_sup dut_i (.*);

  localparam logic [9:0] K_REQ = 10'h300, K_ACT = 10'h0C0, K_REF = 10'h020, K_OSC = 10'h010;
  localparam logic [9:0] K_LOC = 10'h008, K_LOL = 10'h004, K_IRQ = 10'h002, K_RST = 10'h001;

  typedef struct {
    int         due;
    logic [9:0] mask;
    logic [9:0] val;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [9:0] fa(input logic [1:0] m); return {2'b00, m, 6'b0}; endfunction
  function automatic logic [9:0] fr(input logic [1:0] m); return {m, 8'b0}; endfunction

  task automatic chk(input int k, input logic [9:0] mask, input logic [9:0] val, input string tag);
    item_t it;
    it.due = cyc + k; it.mask = mask; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk_i);
      wr_ctrl_i = 0; rd_stat_i = 0; clr_flag_i = 0; ref_loss_i = 0; osc_loss_i = 0;
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic rs, input logic ie, input logic lc, input logic ll);
    wr_ctrl_i = 1; wr_mode_i = m; wr_refsel_i = rs; wr_ie_i = ie;
    wr_loc_rst_en_i = lc; wr_lol_rst_en_i = ll;
  endtask

  task automatic clear_seq;
    rd_stat_i = 1; tick(1);
    clr_flag_i = 1; tick(1);
  endtask

  // monitor: compares items falling due in this cycle
  always @(posedge clk_i) begin
    logic [9:0] obs;
    #1;
    cyc++;
    obs = {req_mode_o, act_mode_o, refsel_o, osc_en_o, loc_flag_o, lol_flag_o, irq_o, rst_req_o};
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        n_cmp++;
        if ((obs & q[i].mask) !== (q[i].val & q[i].mask)) begin
          n_bad++;
          $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b",
                   q[i].tag, cyc, obs & q[i].mask, q[i].val & q[i].mask, q[i].mask);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1;
    chk(1, 10'h3FF, 10'h000, "R1 reset state");
    tick(1);

    // R2 R4: FEI request waits for lock
    wr(2'b01, 1, 1, 0, 0);
    chk(1, K_REQ | K_ACT | K_REF | K_OSC, fr(2'b01) | K_REF | K_OSC, "R2 R11 write");
    chk(3, K_ACT, fa(2'b00), "R4 pending without lock");
    tick(4);
    lock_i = 1;
    chk(1, K_ACT, fa(2'b01), "R4 lock reached");
    tick(1);

    wr(2'b01, 0, 1, 0, 0);
    chk(1, K_REF, K_REF, "R11 second write ignored");
    tick(1);

    // R3: FEE waits for oscillator ready
    wr(2'b11, 0, 1, 0, 0);
    chk(1, K_REQ, fr(2'b11), "R2 req FEE");
    chk(3, K_ACT, fa(2'b01), "R3 pending without ready");
    tick(4);
    osc_rdy_i = 1;
    chk(1, K_ACT, fa(2'b11), "R3 ready reached");
    tick(1);

    // R6 R7: osc loss in FEE
    osc_loss_i = 1;
    chk(1, 10'h3FF & ~(K_REF | K_OSC), fr(2'b10) | fa(2'b10) | K_LOC | K_LOL | K_IRQ, "R6 R7 R9 osc loss");
    tick(1);

    // R8 clear sequence
    clr_flag_i = 1;
    chk(1, K_LOC | K_LOL, K_LOC | K_LOL, "R8 clear without read");
    tick(1);
    rd_stat_i = 1; tick(1);
    clr_flag_i = 1;
    chk(1, K_LOC | K_LOL | K_IRQ, 10'h000, "R8 clear after read");
    tick(1);

    // R5: ref loss in FBE
    osc_stable_i = 0;
    ref_loss_i = 1;
    chk(1, K_REQ | K_ACT | K_LOC | K_LOL | K_IRQ, K_LOC | K_IRQ, "R5 R7 ref loss FBE");
    tick(1);
    clear_seq();

    // R12: osc not monitored until stable
    wr(2'b01, 0, 1, 0, 0);
    chk(2, K_ACT, fa(2'b01), "R2 act FEI");
    tick(2);
    osc_loss_i = 1;
    chk(1, K_ACT | K_LOC | K_LOL, fa(2'b01), "R12 loss ignored unmonitored");
    tick(1);
    osc_stable_i = 1;
    tick(1);
    osc_loss_i = 1;
    chk(1, K_ACT | K_LOC | K_LOL, fa(2'b01) | K_LOC | K_LOL, "R7 R12 loss monitored FEI");
    tick(1);
    clear_seq();

    // R10: clock-loss reset
    wr(2'b01, 0, 1, 1, 0);
    tick(1);
    osc_loss_i = 1;
    chk(1, K_RST | K_LOC, K_RST | K_LOC, "R10 reset pulse");
    chk(2, K_RST, 10'h000, "R10 pulse one cycle");
    tick(2);
    clear_seq();

    // R9 override: lock-loss reset beats interrupt
    wr(2'b01, 0, 1, 0, 1);
    tick(1);
    osc_loss_i = 1;
    chk(1, K_RST | K_IRQ | K_LOC | K_LOL, K_RST | K_LOC | K_LOL, "R9 R10 override");
    tick(1);
    clear_seq();

    // R13: lock drop
    wr(2'b01, 0, 1, 0, 0);
    tick(1);
    lock_i = 0;
    chk(1, K_ACT | K_LOC | K_LOL | K_IRQ, fa(2'b01) | K_LOL | K_IRQ, "R13 lock drop");
    tick(1);
    lock_i = 1;
    clear_seq();

    // R9: interrupts disabled
    wr(2'b01, 0, 0, 0, 0);
    tick(1);
    osc_loss_i = 1;
    chk(1, K_LOC | K_IRQ, K_LOC, "R9 irq masked");
    tick(1);
    clear_seq();

    // R6 priority
    wr(2'b11, 0, 0, 0, 0);
    chk(2, K_ACT, fa(2'b11), "R3 act FEE");
    tick(2);
    ref_loss_i = 1; osc_loss_i = 1;
    chk(1, K_REQ | K_ACT, 10'h000, "R6 ref loss wins");
    tick(1);
    clear_seq();

    // R8 set wins over clear
    wr(2'b10, 0, 0, 0, 0);
    chk(2, K_ACT, fa(2'b10), "R2 act FBE");
    tick(2);
    rd_stat_i = 1; tick(1);
    clr_flag_i = 1; ref_loss_i = 1;
    chk(1, K_LOC | K_ACT, K_LOC, "R8 set wins");
    tick(1);
    clear_seq();

    // R11: first write locks refsel at 0
    rst_ni = 0;
    tick(2);
    rst_ni = 1;
    chk(1, 10'h3FF, 10'h000, "R1 reset again");
    tick(1);
    wr(2'b10, 0, 0, 0, 0);
    chk(1, K_REQ | K_REF | K_OSC, fr(2'b10), "R11 first write zero");
    chk(3, K_ACT, fa(2'b00), "R11 R3 external blocked");
    tick(4);
    wr(2'b10, 1, 0, 0, 0);
    chk(1, K_REF | K_OSC, 10'h000, "R11 refsel stays zero");
    tick(4);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule